// File: doc/BRIEF.md
# Cache Maintenance Command Controller

This block sequences maintenance work for a data cache. Software programs it over a narrow 32-bit register bus and then either triggers a full invalidation of every cache line or asks for a clean, invalidate or clean-and-invalidate pass over a programmed address range. The controller turns each request into a series of single-line operations on a cache line port. Each operation is held until the cache acknowledges it, and the cache may flag a failed write-back in that same cycle.

Busy flags let software know when a pass is running. Sticky completion and error flags record the outcome and are cleared by writing ones. A single interrupt line combines the sticky flags through per-flag enables. Interlocks on the trigger and start bits mean a second pass can never begin while one is already running or pending.

Top module: `cmaint_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `line_req` is 0.
- R2: Word offsets are 0 control, 1 status, 2 interrupt enable, 3 flag clear, 4 range start and 5 range end. The control register holds enable at bit 0, the full-invalidate trigger at bit 1, the command code at bits 10:8 and start at bit 11. The status register holds full-invalidate busy at bit 0, invalidate-done at bit 1, error at bit 2, command busy at bit 3 and command-done at bit 4. The range registers keep bits 31:4 of the written value, and their bits 3:0 read 0.
- R3: A write of 1 to the trigger bit is accepted only when enable already reads 1, neither busy flag is set and neither trigger nor start is pending. Writing 0 to it has no effect. The bit clears in the cycle full-invalidate busy rises.
- R4: A full invalidation issues NUM_LINES requests with op 2'b10 and line addresses 0 to NUM_LINES-1 in order. Busy then falls and invalidate-done rises.
- R5: A write to the command code field is ignored while command busy is 1 or a start is pending.
- R6: A write of 1 to start is accepted only when enable already reads 1, neither busy flag is set, nothing is pending and the written code is 001 (clean), 010 (invalidate) or 011 (clean-and-invalidate). Other codes never start a pass. The start bit clears in the cycle command busy rises.
- R7: A range pass issues one request per line from the start line to the end line inclusive, in ascending order, with `line_op` equal to code bits 1:0. Each request is held until it is acknowledged. Command busy falls and command-done rises on the clock edge that takes the last acknowledge.
- R8: If the end line is below the start line, exactly one request is issued, for the start line.
- R9: The error flag is set when an acknowledge carries `line_err` and the op includes a clean (`line_op[0]`=1). An error on an invalidate-only op is ignored.
- R10: Writing 1 to clear-register bit 1, 2 or 4 clears invalidate-done, error or command-done respectively. Writing 0 leaves the flag unchanged.
- R11: `irq` is the OR of each sticky flag ANDed with its enable, which sits at the same bit position in the interrupt enable register (1, 2, 4).
- R12: When a flag is set and cleared in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| line_req | output | 1 | Line operation request, held until acknowledged |
| line_op | output | 2 | 01 clean, 10 invalidate, 11 clean-and-invalidate |
| line_addr | output | 28 | Line address (range pass) or line index (full invalidation) |
| line_ack | input | 1 | Acknowledge of the current request |
| line_err | input | 1 | Write-back failure, valid with `line_ack` |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sweeps every legal command code over range lengths of one to four lines, using several acknowledge latencies. It checks the exact request sequence for each run: a walker that stops early or overruns the end line, or that issues a wrong op, shows up in the request log. It also attacks the interlocks. It starts a pass while another is running, rewrites the code mid-pass, uses reserved codes and triggers with enable low. A design that ignored an interlock would issue extra requests or change the code readback. Further cases cover an inverted range, an error on an invalidate-only op, and a clear held continuously across the completion edge. A design where clear beats set would never raise `irq` in that last case.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_FULL  = 2'd1,
    WK_RANGE = 2'd2
  } walk_st_t;

  // register word offsets
  localparam int REG_CTRL   = 0;
  localparam int REG_STAT   = 1;
  localparam int REG_IE     = 2;
  localparam int REG_CLR    = 3;
  localparam int REG_RSTART = 4;
  localparam int REG_REND   = 5;

  // control field positions
  localparam int CTL_EN    = 0;
  localparam int CTL_INV   = 1;
  localparam int CTL_CODE  = 8;
  localparam int CTL_START = 11;

  // sticky flag positions shared by status, enable and clear registers
  localparam int NFLAG = 3;
  localparam int FLAG_BIT [NFLAG] = '{1, 2, 4};
  localparam int FL_FDONE = 0;
  localparam int FL_ERR   = 1;
  localparam int FL_CDONE = 2;

  localparam logic [1:0] OP_INVAL = 2'b10;

endpackage

// File: rtl/cmaint_regs.sv
module cmaint_regs
  import cmaint_pkg::*;
#(
  parameter int LINE_AW = 28,
  parameter int RA_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wen,
  input  logic [RA_W-1:0]    bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               full_busy,
  input  logic               cmd_busy,
  input  logic               launch_full,
  input  logic               launch_cmd,
  input  logic [NFLAG-1:0]   flag_set,
  output logic               inv_go,
  output logic               start_go,
  output logic [2:0]         cmd_code,
  output logic [LINE_AW-1:0] rng_start,
  output logic [LINE_AW-1:0] rng_end,
  output logic [NFLAG-1:0]   flags,
  output logic [NFLAG-1:0]   irq_en
);

  logic               en_q, en_d;
  logic               inv_q, inv_d;
  logic               start_q, start_d;
  logic [2:0]         code_q, code_d;
  logic [NFLAG-1:0]   ie_q, ie_d;
  logic [NFLAG-1:0]   flg_q, flg_d;
  logic [LINE_AW-1:0] rs_q, re_q;

  logic wr_ctl, wr_ie, wr_clr, wr_rs, wr_re;
  logic quiet, code_ok, inv_acc, start_acc;
  logic unused_wdata;

  assign unused_wdata = ^{bus_wdata[31:12], bus_wdata[7:2]};

  always_comb begin
    wr_ctl = bus_wen && (bus_addr == RA_W'(REG_CTRL));
    wr_ie  = bus_wen && (bus_addr == RA_W'(REG_IE));
    wr_clr = bus_wen && (bus_addr == RA_W'(REG_CLR));
    wr_rs  = bus_wen && (bus_addr == RA_W'(REG_RSTART));
    wr_re  = bus_wen && (bus_addr == RA_W'(REG_REND));

    quiet     = !full_busy && !cmd_busy && !inv_q && !start_q;
    code_ok   = (bus_wdata[CTL_CODE+:3] == 3'b001) ||
                (bus_wdata[CTL_CODE+:3] == 3'b010) ||
                (bus_wdata[CTL_CODE+:3] == 3'b011);
    inv_acc   = wr_ctl && bus_wdata[CTL_INV] && en_q && quiet;
    start_acc = wr_ctl && bus_wdata[CTL_START] && en_q && quiet && code_ok;

    en_d = wr_ctl ? bus_wdata[CTL_EN] : en_q;

    inv_d = inv_q;
    if (launch_full)  inv_d = 1'b0;
    else if (inv_acc) inv_d = 1'b1;

    start_d = start_q;
    if (launch_cmd)     start_d = 1'b0;
    else if (start_acc) start_d = 1'b1;

    code_d = code_q;
    if (wr_ctl && !cmd_busy && !start_q) code_d = bus_wdata[CTL_CODE+:3];

    ie_d = ie_q;
    for (int i = 0; i < NFLAG; i++) begin
      if (wr_ie) ie_d[i] = bus_wdata[FLAG_BIT[i]];
      flg_d[i] = flag_set[i] | (flg_q[i] & ~(wr_clr & bus_wdata[FLAG_BIT[i]]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      inv_q   <= 1'b0;
      start_q <= 1'b0;
      code_q  <= '0;
      ie_q    <= '0;
      flg_q   <= '0;
      rs_q    <= '0;
      re_q    <= '0;
    end else begin
      en_q    <= en_d;
      inv_q   <= inv_d;
      start_q <= start_d;
      code_q  <= code_d;
      ie_q    <= ie_d;
      flg_q   <= flg_d;
      if (wr_rs) rs_q <= bus_wdata[LINE_AW+3:4];
      if (wr_re) re_q <= bus_wdata[LINE_AW+3:4];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_W'(REG_CTRL): begin
        bus_rdata[CTL_EN]       = en_q;
        bus_rdata[CTL_INV]      = inv_q;
        bus_rdata[CTL_CODE+:3]  = code_q;
        bus_rdata[CTL_START]    = start_q;
      end
      RA_W'(REG_STAT): begin
        bus_rdata[0] = full_busy;
        bus_rdata[3] = cmd_busy;
        for (int i = 0; i < NFLAG; i++) bus_rdata[FLAG_BIT[i]] = flg_q[i];
      end
      RA_W'(REG_IE): begin
        for (int i = 0; i < NFLAG; i++) bus_rdata[FLAG_BIT[i]] = ie_q[i];
      end
      RA_W'(REG_RSTART): bus_rdata = 32'({rs_q, 4'b0000});
      RA_W'(REG_REND):   bus_rdata = 32'({re_q, 4'b0000});
      default:           bus_rdata = '0;
    endcase
  end

  assign inv_go    = inv_q;
  assign start_go  = start_q;
  assign cmd_code  = code_q;
  assign rng_start = rs_q;
  assign rng_end   = re_q;
  assign flags     = flg_q;
  assign irq_en    = ie_q;

  // trigger and start bits are gone once the matching busy flag is up
  assert_inv_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_busy) |-> !inv_q);
  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_busy) |-> !start_q);
  // code field frozen while a range pass runs
  assert_code_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && $past(cmd_busy)) |-> $stable(code_q));
  // a set event always lands, whatever the clear register says
  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[FL_CDONE] |=> flg_q[FL_CDONE]);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[FL_ERR] |=> flg_q[FL_ERR]);

endmodule

// File: rtl/cmaint_walker.sv
module cmaint_walker
  import cmaint_pkg::*;
#(
  parameter int LINE_AW   = 28,
  parameter int NUM_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inv_go,
  input  logic               start_go,
  input  logic [1:0]         op_code,
  input  logic [LINE_AW-1:0] rng_start,
  input  logic [LINE_AW-1:0] rng_end,
  output logic               launch_full,
  output logic               launch_cmd,
  output logic               full_busy,
  output logic               cmd_busy,
  output logic               fin_full,
  output logic               fin_cmd,
  output logic               err_evt,
  output logic               line_req,
  output logic [1:0]         line_op,
  output logic [LINE_AW-1:0] line_addr,
  input  logic               line_ack,
  input  logic               line_err
);

  localparam logic [LINE_AW-1:0] LAST_IDX = LINE_AW'(NUM_LINES - 1);

  walk_st_t           st_q, st_d;
  logic [LINE_AW-1:0] addr_q, addr_d;
  logic [LINE_AW-1:0] end_q, end_d;
  logic [1:0]         op_q, op_d;
  logic               hs, last;

  always_comb begin
    hs          = (st_q != WK_IDLE) && line_ack;
    last        = (st_q == WK_FULL) ? (addr_q == LAST_IDX) : (addr_q >= end_q);
    launch_full = (st_q == WK_IDLE) && inv_go;
    launch_cmd  = (st_q == WK_IDLE) && start_go && !inv_go;

    st_d   = st_q;
    addr_d = addr_q;
    end_d  = end_q;
    op_d   = op_q;

    case (st_q)
      WK_IDLE: begin
        if (launch_full) begin
          st_d   = WK_FULL;
          addr_d = '0;
          op_d   = OP_INVAL;
        end else if (launch_cmd) begin
          st_d   = WK_RANGE;
          addr_d = rng_start;
          end_d  = rng_end;
          op_d   = op_code;
        end
      end
      WK_FULL, WK_RANGE: begin
        if (hs) begin
          if (last) st_d = WK_IDLE;
          else      addr_d = addr_q + 1'b1;
        end
      end
      default: st_d = WK_IDLE;
    endcase

    fin_full = (st_q == WK_FULL) && hs && last;
    fin_cmd  = (st_q == WK_RANGE) && hs && last;
    err_evt  = hs && line_err && op_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      addr_q <= '0;
      end_q  <= '0;
      op_q   <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      end_q  <= end_d;
      op_q   <= op_d;
    end
  end

  assign full_busy = (st_q == WK_FULL);
  assign cmd_busy  = (st_q == WK_RANGE);
  assign line_req  = (st_q != WK_IDLE);
  assign line_op   = op_q;
  assign line_addr = addr_q;

  // an unacknowledged request keeps its address and op
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_req && !line_ack) |=> (line_req && $stable(line_addr) && $stable(line_op)));
  // range walk steps upward one line per acknowledge
  assert_ascend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && line_ack && !fin_cmd) |=> (line_addr == $past(line_addr) + 1'b1));
  // full invalidation never cleans
  assert_full_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full_busy |-> (line_op == OP_INVAL));
  assert_full_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_busy) |-> (line_addr == '0));

endmodule

// File: rtl/cmaint_irq.sv
module cmaint_irq
  import cmaint_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] irq_en,
  output logic             irq
);

  logic [NFLAG-1:0] hit;

  for (genvar g = 0; g < NFLAG; g++) begin : g_src
    assign hit[g] = flags[g] & irq_en[g];
  end

  assign irq = |hit;

endmodule

// File: rtl/cmaint_ctrl.sv
module cmaint_ctrl
  import cmaint_pkg::*;
#(
  parameter int LINE_AW   = 28,
  parameter int NUM_LINES = 8,
  parameter int RA_W      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wen,
  input  logic [RA_W-1:0]    bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               line_req,
  output logic [1:0]         line_op,
  output logic [LINE_AW-1:0] line_addr,
  input  logic               line_ack,
  input  logic               line_err,
  output logic               irq
);

  logic               full_busy, cmd_busy, launch_full, launch_cmd;
  logic               fin_full, fin_cmd, err_evt;
  logic               inv_go, start_go;
  logic [2:0]         cmd_code;
  logic [LINE_AW-1:0] rng_start, rng_end;
  logic [NFLAG-1:0]   flags, irq_en, flag_set;
  logic               unused_code;

  assign unused_code = cmd_code[2];

  always_comb begin
    flag_set           = '0;
    flag_set[FL_FDONE] = fin_full;
    flag_set[FL_ERR]   = err_evt;
    flag_set[FL_CDONE] = fin_cmd;
  end

  cmaint_regs #(.LINE_AW(LINE_AW), .RA_W(RA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wen     (bus_wen),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .full_busy   (full_busy),
    .cmd_busy    (cmd_busy),
    .launch_full (launch_full),
    .launch_cmd  (launch_cmd),
    .flag_set    (flag_set),
    .inv_go      (inv_go),
    .start_go    (start_go),
    .cmd_code    (cmd_code),
    .rng_start   (rng_start),
    .rng_end     (rng_end),
    .flags       (flags),
    .irq_en      (irq_en)
  );

  cmaint_walker #(.LINE_AW(LINE_AW), .NUM_LINES(NUM_LINES)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .inv_go      (inv_go),
    .start_go    (start_go),
    .op_code     (cmd_code[1:0]),
    .rng_start   (rng_start),
    .rng_end     (rng_end),
    .launch_full (launch_full),
    .launch_cmd  (launch_cmd),
    .full_busy   (full_busy),
    .cmd_busy    (cmd_busy),
    .fin_full    (fin_full),
    .fin_cmd     (fin_cmd),
    .err_evt     (err_evt),
    .line_req    (line_req),
    .line_op     (line_op),
    .line_addr   (line_addr),
    .line_ack    (line_ack),
    .line_err    (line_err)
  );

  cmaint_irq u_irq (
    .flags  (flags),
    .irq_en (irq_en),
    .irq    (irq)
  );

  // at most one pass runs at a time
  assert_one_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_busy && cmd_busy));
  assert_irq_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flags));

endmodule

// File: tb/cmaint_ctrl_test.sv
module cmaint_ctrl_test;

  localparam int NL = 4;

  logic        clk, rst_n;
  logic        bus_wen;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        line_req, line_ack, line_err, irq;
  logic [1:0]  line_op;
  logic [27:0] line_addr;

  int n_chk = 0;
  int n_fail = 0;

  int lat = 0;
  int err_at = -1;
  int log_n = 0;
  logic [1:0]  log_op   [0:63];
  logic [27:0] log_addr [0:63];

  cmaint_ctrl #(.NUM_LINES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_req(line_req),
    .line_op(line_op), .line_addr(line_addr), .line_ack(line_ack),
    .line_err(line_err), .irq(irq)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // cache line port model: ack after lat waiting cycles
  initial begin
    int wcnt;
    wcnt = 0;
    line_ack = 0;
    line_err = 0;
    forever begin
      @(negedge clk);
      line_ack = 0;
      line_err = 0;
      if (rst_n && line_req) begin
        if (wcnt >= lat) begin
          log_op[log_n & 63]   = line_op;
          log_addr[log_n & 63] = line_addr;
          line_ack = 1;
          line_err = (log_n == err_at);
          log_n++;
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, s);
      if ((s & 32'h9) == 0) break;
    end
  endtask

  function automatic logic [31:0] ctl(input logic [2:0] code, input bit start);
    return 32'h1 | (32'(code) << 8) | (start ? 32'h800 : 32'h0);
  endfunction

  // range pass from line s to line e with the given code; checks the log
  task automatic run_range(input string tag, input logic [2:0] code,
                           input int s, input int e, input int exp_n);
    int base;
    logic [31:0] st;
    bit ok;
    base = log_n;
    wr(3'd4, 32'(s) << 4);
    wr(3'd5, 32'(e) << 4);
    wr(3'd0, ctl(code, 1));
    wait_idle();
    chk({tag, " count"}, 32'(log_n - base), 32'(exp_n));
    ok = 1;
    for (int i = 0; i < exp_n; i++) begin
      if (log_addr[(base + i) & 63] !== 28'(s + i)) ok = 0;
      if (log_op[(base + i) & 63] !== code[1:0]) ok = 0;
    end
    chk({tag, " sequence"}, 32'(ok), 32'd1);
    rd(3'd1, st);
    chk({tag, " done flag"}, st & 32'h19, 32'h10);
    wr(3'd3, 32'h10);
  endtask

  initial begin
    logic [31:0] d;
    int base;
    bit seen;
    bus_wen = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reg %0d", a), d, 0);
    end
    chk("R1 irq", 32'(irq), 0);
    chk("R1 line_req", 32'(line_req), 0);

    // R2 range register keeps bits 31:4
    wr(3'd4, 32'hABCD_EF17);
    rd(3'd4, d);
    chk("R2 range start readback", d, 32'hABCD_EF10);
    wr(3'd5, 32'h1234_567F);
    rd(3'd5, d);
    chk("R2 range end readback", d, 32'h1234_5670);

    // R3 trigger with enable low is refused
    base = log_n;
    wr(3'd0, 32'h2);
    rd(3'd0, d);
    chk("R3 trigger refused when disabled", d, 0);
    // R6 start with enable low is refused
    wr(3'd0, 32'h0000_0900);
    rd(3'd0, d);
    chk("R6 start refused when disabled", d & 32'h800, 0);
    repeat (5) @(negedge clk);
    chk("R6 no requests when disabled", 32'(log_n - base), 0);

    // enable
    wr(3'd0, 32'h1);

    // R6 reserved codes never start a pass
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 3) continue;
      base = log_n;
      wr(3'd0, ctl(3'(c), 1));
      rd(3'd0, d);
      chk($sformatf("R6 code %0d start bit", c), d & 32'h800, 0);
      repeat (4) @(negedge clk);
      chk($sformatf("R6 code %0d no requests", c), 32'(log_n - base), 0);
    end

    // R7 sweep over codes, lengths and latencies
    for (int c = 1; c <= 3; c++) begin
      for (int len = 1; len <= 4; len++) begin
        lat = (c + len) % 3;
        run_range($sformatf("R7 code %0d len %0d", c, len), 3'(c),
                  16 * c + len, 16 * c + 2 * len - 1, len);
      end
    end

    // R8 end below start
    lat = 1;
    run_range("R8 inverted range", 3'd2, 5, 2, 1);

    // R6 start bit self-clears as busy rises; R5 code frozen while busy
    lat = 5;
    base = log_n;
    wr(3'd4, 32'h100);
    wr(3'd5, 32'h130);
    wr(3'd0, ctl(3'd1, 1));
    rd(3'd0, d);
    chk("R6 start cleared once busy", d & 32'h800, 0);
    rd(3'd1, d);
    chk("R6 command busy", d & 32'h8, 32'h8);
    wr(3'd0, ctl(3'd2, 0));
    rd(3'd0, d);
    chk("R5 code kept during pass", (d >> 8) & 7, 1);
    wr(3'd0, ctl(3'd3, 1));
    wr(3'd0, 32'h3);
    wait_idle();
    chk("R6 second start ignored", 32'(log_n - base), 4);
    seen = 1;
    for (int i = 0; i < 4; i++) if (log_op[(base + i) & 63] !== 2'b01) seen = 0;
    chk("R5 ops stayed clean", 32'(seen), 1);
    rd(3'd1, d);
    chk("R3 trigger while busy ignored", d & 32'h3, 0);
    wr(3'd0, ctl(3'd2, 0));
    rd(3'd0, d);
    chk("R5 code writable when idle", (d >> 8) & 7, 2);

    // R10 zero write leaves flag, one clears it
    wr(3'd3, 32'h0);
    rd(3'd1, d);
    chk("R10 zero write keeps done", d & 32'h10, 32'h10);
    wr(3'd3, 32'h10);
    rd(3'd1, d);
    chk("R10 write one clears done", d & 32'h10, 0);

    // R4 full invalidation; R6 start refused while it runs
    lat = 3;
    base = log_n;
    wr(3'd0, 32'h3);
    rd(3'd0, d);
    chk("R3 trigger cleared once busy", d & 32'h2, 0);
    rd(3'd1, d);
    chk("R4 full busy", d & 32'h9, 32'h1);
    wr(3'd0, ctl(3'd1, 1));
    wait_idle();
    chk("R4 request count", 32'(log_n - base), NL);
    seen = 1;
    for (int i = 0; i < NL; i++) begin
      if (log_addr[(base + i) & 63] !== 28'(i)) seen = 0;
      if (log_op[(base + i) & 63] !== 2'b10) seen = 0;
    end
    chk("R4 sequence", 32'(seen), 1);
    rd(3'd1, d);
    chk("R4 invalidate done, no command done", d & 32'h1B, 32'h2);
    wr(3'd3, 32'h2);
    rd(3'd1, d);
    chk("R10 clear invalidate done", d & 32'h2, 0);

    // R9 error on clean, ignored on invalidate only
    lat = 0;
    err_at = log_n + 1;
    run_range("R9 clean with error", 3'd1, 8, 10, 3);
    rd(3'd1, d);
    chk("R9 error flag set", d & 32'h4, 32'h4);
    // R11 error interrupt
    chk("R11 irq masked", 32'(irq), 0);
    wr(3'd2, 32'h4);
    @(negedge clk);
    chk("R11 irq from error", 32'(irq), 1);
    wr(3'd3, 32'h4);
    @(negedge clk);
    chk("R11 irq falls after clear", 32'(irq), 0);
    err_at = log_n + 1;
    run_range("R9 invalidate with error", 3'd2, 8, 10, 3);
    rd(3'd1, d);
    chk("R9 invalidate error ignored", d & 32'h4, 0);
    err_at = -1;

    // R12 clear held across the completion edge; set must win
    wr(3'd2, 32'h10);
    lat = 2;
    wr(3'd4, 32'h40);
    wr(3'd5, 32'h40);
    wr(3'd0, ctl(3'd3, 1));
    @(negedge clk);
    bus_wen = 1; bus_addr = 3'd3; bus_wdata = 32'h16;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      #1 if (irq) seen = 1;
    end
    bus_wen = 0;
    chk("R12 set wins over clear", 32'(seen), 1);
    rd(3'd1, d);
    chk("R12 later clear takes effect", d & 32'h1F, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule